// File: doc/BRIEF.md
# RGMII Receive Command Parser

This block sits on the receive side of a gigabit PHY link and listens for control commands sent from a host PC. It rebuilds bytes from the 4-bit double-data-rate receive bus and finds the frame start after the preamble. It runs a CRC-32 over the frame and reads a five-byte command header from the start of the UDP payload of an IPv4 frame. A command code, an operation code, a target device number and a 16-bit size are then presented to the acquisition-board control logic.

The decoded fields are held in a shadow buffer while the frame is still arriving. They are released only after the frame has ended with a good CRC, as a single-cycle strobe. A frame that carried a receive error, failed its CRC or was too short to hold the command header does not produce a command. It increments a drop counter instead. A well-formed frame that is not IPv4/UDP is discarded without any effect.

Top module: `rgmii_cmd_rx`

## Requirements
- R1: A byte is assembled from the low nibble sampled on the rising edge of `rxc` and the high nibble sampled on the following falling edge. Data-valid is `rx_ctl` on the rising edge. Receive error is the XOR of the rising-edge and falling-edge samples of `rx_ctl`.
- R2: A frame starts with one or more 0x55 bytes followed by 0xD5. If any other byte appears before 0xD5, the whole valid burst is ignored: no strobe and no change to the drop count unless R7 applies.
- R3: The CRC-32 (reflected, polynomial 0x04C11DB7, initial value all ones) covers every byte after 0xD5, up to and including the four FCS bytes. The frame is good when the register ends at 0xDEBB20E3, which is the bit-reversed form of 0xC704DD7B.
- R4: Byte offsets are counted from the first byte after 0xD5. The command code is at offset 42, the operation code at 43, the device number at 44, and the size at 45 (high byte) and 46 (low byte).
- R5: `cmd_valid` is high for exactly one cycle, on the third rising edge after the first non-valid byte slot that ends the frame. It is raised only if all of these hold: the CRC is good, there was no receive error, the frame is at least 51 bytes including the FCS, offsets 12–13 read 0x08 0x00, offset 14 reads 0x45, and offset 23 reads 0x11.
- R6: The command outputs change only on the cycle `cmd_valid` is high, and hold their values between strobes.
- R7: `drop_count` increases by exactly one, on the same cycle a strobe would have appeared, for a burst that had a receive error, or for a started frame that had a bad CRC or was shorter than 51 bytes. It never changes together with `cmd_valid`.
- R8: A frame with a good CRC and sufficient length but a non-matching type, version or protocol byte produces neither a strobe nor a drop.
- R9: A receive-error indication while data-valid is low has no effect.
- R10: While reset is asserted, every output is zero.
- R11: Two frames separated by a single non-valid byte slot are each parsed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rxc | input | 1 | Receive clock from the PHY; both edges carry data |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 4 | Receive data nibble |
| rx_ctl | input | 1 | Receive control: valid on rising edge, valid XOR error on falling edge |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_code | output | 8 | Command code |
| cmd_op | output | 8 | Operation code |
| cmd_dev | output | 8 | Target device number |
| cmd_size | output | 16 | Size field, big-endian on the wire |
| drop_count | output | DROP_W | Count of rejected frames, wraps |

## Verification
The hardest situation to reach is a receive error that shows up only on the falling edge of the control line in the middle of a frame whose CRC is otherwise good. The bench drives the two halves of `rx_ctl` separately, so it can set the error at any chosen byte of a correctly built frame. A second hard case is a new preamble arriving one byte slot after the previous FCS. The bench sends frames with a gap of exactly one idle slot, so the end-of-frame decision and the next start both fall in adjacent cycles. A reference model is compared every cycle and checks that the strobe and the counter step land on the exact expected edge.

// File: rtl/rgmii_cmd_rx.sv
`timescale 1ns/1ps
module rgmii_cmd_rx #(
  parameter int CNT_W   = 12,
  parameter int DROP_W  = 16,
  parameter int CMD_OFS = 42
) (
  input  logic              rxc,
  input  logic              rst_n,
  input  logic [3:0]        rxd,
  input  logic              rx_ctl,
  output logic              cmd_valid,
  output logic [7:0]        cmd_code,
  output logic [7:0]        cmd_op,
  output logic [7:0]        cmd_dev,
  output logic [15:0]       cmd_size,
  output logic [DROP_W-1:0] drop_count
);
  localparam logic [CNT_W-1:0] O_ET0   = CNT_W'(12);
  localparam logic [CNT_W-1:0] O_ET1   = CNT_W'(13);
  localparam logic [CNT_W-1:0] O_VER   = CNT_W'(14);
  localparam logic [CNT_W-1:0] O_PROTO = CNT_W'(23);
  localparam logic [CNT_W-1:0] O_CODE  = CNT_W'(CMD_OFS);
  localparam logic [CNT_W-1:0] O_OP    = CNT_W'(CMD_OFS + 1);
  localparam logic [CNT_W-1:0] O_DEV   = CNT_W'(CMD_OFS + 2);
  localparam logic [CNT_W-1:0] O_SZH   = CNT_W'(CMD_OFS + 3);
  localparam logic [CNT_W-1:0] O_SZL   = CNT_W'(CMD_OFS + 4);
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(CMD_OFS + 9);
  localparam logic [31:0]      RESIDUE = 32'hDEBB20E3;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_BODY, S_SKIP} st_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ ((r[0] ^ d[i]) ? 32'hEDB88320 : 32'h0);
    return r;
  endfunction

  logic [3:0] hi_n;
  logic       ctl_f;
  always_ff @(negedge rxc or negedge rst_n)
    if (!rst_n) begin
      hi_n  <= '0;
      ctl_f <= 1'b0;
    end else begin
      hi_n  <= rxd;
      ctl_f <= rx_ctl;
    end

  logic [3:0] lo_q;
  logic       ctl_r;
  logic [7:0] rx_byte;
  logic       rx_dv, rx_er;
  always_ff @(posedge rxc or negedge rst_n)
    if (!rst_n) begin
      lo_q    <= '0;
      ctl_r   <= 1'b0;
      rx_byte <= '0;
      rx_dv   <= 1'b0;
      rx_er   <= 1'b0;
    end else begin
      lo_q    <= rxd;
      ctl_r   <= rx_ctl;
      rx_byte <= {hi_n, lo_q};
      rx_dv   <= ctl_r;
      rx_er   <= ctl_r ^ ctl_f;
    end

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      crc;
  logic             err_f, type_ok;
  logic [7:0]       sh_code, sh_op, sh_dev;
  logic [15:0]      sh_size;

  wire frame_end = !rx_dv && (st != S_IDLE);
  wire body_ok   = (crc == RESIDUE) && (cnt >= MIN_LEN);
  wire drop_now  = frame_end && (err_f || ((st == S_BODY) && !body_ok));
  wire hit_now   = frame_end && (st == S_BODY) && !err_f && body_ok && type_ok;

  always_ff @(posedge rxc or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      crc     <= '1;
      err_f   <= 1'b0;
      type_ok <= 1'b1;
      sh_code <= '0;
      sh_op   <= '0;
      sh_dev  <= '0;
      sh_size <= '0;
    end else begin
      err_f <= (st == S_IDLE) ? (rx_dv && rx_er) : (err_f || (rx_dv && rx_er));
      case (st)
        S_IDLE: begin
          cnt     <= '0;
          crc     <= '1;
          type_ok <= 1'b1;
          if (rx_dv) st <= (rx_byte == 8'h55 && !rx_er) ? S_PRE : S_SKIP;
        end
        S_PRE: begin
          if (!rx_dv)                st <= S_IDLE;
          else if (rx_er)            st <= S_SKIP;
          else if (rx_byte == 8'hD5) st <= S_BODY;
          else if (rx_byte != 8'h55) st <= S_SKIP;
        end
        S_BODY: begin
          if (!rx_dv) st <= S_IDLE;
          else begin
            crc <= crc_step(crc, rx_byte);
            if (cnt != '1) cnt <= cnt + 1'b1;
            case (cnt)
              O_ET0:   if (rx_byte != 8'h08) type_ok <= 1'b0;
              O_ET1:   if (rx_byte != 8'h00) type_ok <= 1'b0;
              O_VER:   if (rx_byte != 8'h45) type_ok <= 1'b0;
              O_PROTO: if (rx_byte != 8'h11) type_ok <= 1'b0;
              O_CODE:  sh_code <= rx_byte;
              O_OP:    sh_op   <= rx_byte;
              O_DEV:   sh_dev  <= rx_byte;
              O_SZH:   sh_size[15:8] <= rx_byte;
              O_SZL:   sh_size[7:0]  <= rx_byte;
              default: ;
            endcase
          end
        end
        default: if (!rx_dv) st <= S_IDLE;
      endcase
    end

  always_ff @(posedge rxc or negedge rst_n)
    if (!rst_n) begin
      cmd_valid  <= 1'b0;
      cmd_code   <= '0;
      cmd_op     <= '0;
      cmd_dev    <= '0;
      cmd_size   <= '0;
      drop_count <= '0;
    end else begin
      cmd_valid <= hit_now;
      if (hit_now) begin
        cmd_code <= sh_code;
        cmd_op   <= sh_op;
        cmd_dev  <= sh_dev;
        cmd_size <= sh_size;
      end
      if (drop_now) drop_count <= drop_count + 1'b1;
    end
endmodule

// File: rtl/rgmii_cmd_rx_chk.sv
`timescale 1ns/1ps
module rgmii_cmd_rx_chk #(
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [39:0]       fields,
  input logic [DROP_W-1:0] drop_count
);
  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R5
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(fields)); // R6
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1)); // R7
  AST_STROBE_NOT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (drop_count == $past(drop_count))); // R7
endmodule

bind rgmii_cmd_rx rgmii_cmd_rx_chk #(.DROP_W(DROP_W)) u_chk (
  .clk(rxc), .rst_n(rst_n), .cmd_valid(cmd_valid),
  .fields({cmd_code, cmd_op, cmd_dev, cmd_size}), .drop_count(drop_count));

// File: tb/rgmii_cmd_rx_test.sv
`timescale 1ns/1ps
module rgmii_cmd_rx_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, rx_ctl, cmd_valid;
  logic [3:0] rxd;
  logic [7:0] cmd_code, cmd_op, cmd_dev;
  logic [15:0] cmd_size, drop_count;

  rgmii_cmd_rx uut (.rxc(clk), .rst_n(rst_n), .rxd(rxd), .rx_ctl(rx_ctl),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_op(cmd_op),
    .cmd_dev(cmd_dev), .cmd_size(cmd_size), .drop_count(drop_count));

  int checks = 0, errors = 0, cyc = 0;
  bit mon_en = 0;
  string cur_req = "R10";
  always @(posedge clk) cyc <= cyc + 1;

  int exp_cyc_q[$];
  bit exp_hit_q[$];
  logic [39:0] exp_fld_q[$];
  logic [39:0] mdl_fld = '0;
  logic [15:0] mdl_drop = '0;

  always @(negedge clk) if (mon_en) begin
    bit ev;
    ev = 0;
    if (exp_cyc_q.size() > 0 && exp_cyc_q[0] == cyc) begin
      ev = exp_hit_q[0];
      if (exp_hit_q[0]) mdl_fld = exp_fld_q[0];
      else mdl_drop = mdl_drop + 1'b1;
      void'(exp_cyc_q.pop_front()); void'(exp_hit_q.pop_front()); void'(exp_fld_q.pop_front());
    end
    checks++;
    if (cmd_valid !== ev || {cmd_code, cmd_op, cmd_dev, cmd_size} !== mdl_fld || drop_count !== mdl_drop) begin
      errors++;
      $display("FAIL %s cycle %0d: valid=%0b fields=%h drops=%0d expected valid=%0b fields=%h drops=%0d",
        cur_req, cyc, cmd_valid, {cmd_code, cmd_op, cmd_dev, cmd_size}, drop_count, ev, mdl_fld, mdl_drop);
    end
  end

  task automatic drive(input logic [7:0] b, input bit dv, input bit er, output int slot);
    @(negedge clk); #1 rxd = b[3:0]; rx_ctl = dv;
    @(posedge clk); #1 slot = cyc; rxd = b[7:4]; rx_ctl = dv ^ er;
  endtask

  function automatic logic [31:0] crc_of(input logic [7:0] q[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (q[k]) begin
      c = c ^ {24'h0, q[k]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  task automatic send_frame(input int npre, input bit bad_pre, input logic [15:0] et,
      input logic [7:0] vi, input logic [7:0] pr, input logic [7:0] c, input logic [7:0] o,
      input logic [7:0] d, input logic [15:0] sz, input int body_len, input bit bad_crc,
      input int err_at, input int gap);
    logic [7:0] q[$];
    logic [31:0] f;
    int slot, total;
    bit drop, hit;
    for (int i = 0; i < 12; i++) q.push_back(8'h10 + 8'(i));
    q.push_back(et[15:8]); q.push_back(et[7:0]); q.push_back(vi);
    for (int i = 15; i < 23; i++) q.push_back(8'h00);
    q.push_back(pr);
    for (int i = 24; i < 42; i++) q.push_back(8'h3C);
    q.push_back(c); q.push_back(o); q.push_back(d); q.push_back(sz[15:8]); q.push_back(sz[7:0]);
    while (q.size() < body_len) q.push_back(8'hA5 ^ 8'(q.size()));
    while (q.size() > body_len) void'(q.pop_back());
    f = ~crc_of(q);
    for (int i = 0; i < 4; i++) q.push_back(f[8*i +: 8]);
    if (bad_crc) q[q.size()-1] = q[q.size()-1] ^ 8'h01;
    total = q.size();
    for (int p = 0; p < npre; p++) drive((bad_pre && p == npre-1) ? 8'h54 : 8'h55, 1, 0, slot);
    drive(8'hD5, 1, 0, slot);
    foreach (q[k]) drive(q[k], 1, (k == err_at), slot);
    drive(8'h00, 0, 0, slot);
    drop = (err_at >= 0) || (!bad_pre && (bad_crc || total < 51));
    hit  = !bad_pre && !drop && et == 16'h0800 && vi == 8'h45 && pr == 8'h11;
    if (hit || drop) begin
      exp_cyc_q.push_back(slot + 2); exp_hit_q.push_back(hit); exp_fld_q.push_back({c, o, d, sz});
    end
    for (int g = 0; g < gap; g++) drive(8'h00, 0, 0, slot);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s;
    rst_n = 0; rxd = 4'h0; rx_ctl = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({cmd_valid, cmd_code, cmd_op, cmd_dev, cmd_size, drop_count} !== '0) begin
      errors++;
      $display("FAIL R10 reset: outputs=%h expected 0", {cmd_valid, cmd_code, cmd_op, cmd_dev, cmd_size, drop_count});
    end
    rst_n = 1; mon_en = 1;
    repeat (3) drive(8'h00, 0, 0, s);

    cur_req = "R1 R3 R4 R5";
    send_frame(7, 0, 16'h0800, 8'h45, 8'h11, 8'h12, 8'h34, 8'h56, 16'h789A, 60, 0, -1, 6);
    cur_req = "R4";
    send_frame(7, 0, 16'h0800, 8'h45, 8'h11, 8'hC3, 8'h5A, 8'h01, 16'hFFFF, 300, 0, -1, 6);
    cur_req = "R3 R6 R7";
    send_frame(7, 0, 16'h0800, 8'h45, 8'h11, 8'h99, 8'h99, 8'h99, 16'h9999, 60, 1, -1, 6);
    cur_req = "R1 R7";
    send_frame(7, 0, 16'h0800, 8'h45, 8'h11, 8'h77, 8'h77, 8'h77, 16'h7777, 60, 0, 20, 6);
    cur_req = "R8";
    send_frame(7, 0, 16'h0806, 8'h45, 8'h11, 8'h66, 8'h66, 8'h66, 16'h6666, 60, 0, -1, 6);
    send_frame(7, 0, 16'h0800, 8'h45, 8'h06, 8'h65, 8'h65, 8'h65, 16'h6565, 60, 0, -1, 6);
    send_frame(7, 0, 16'h0800, 8'h46, 8'h11, 8'h64, 8'h64, 8'h64, 16'h6464, 60, 0, -1, 6);
    cur_req = "R7 short";
    send_frame(7, 0, 16'h0800, 8'h45, 8'h11, 8'h55, 8'h55, 8'h55, 16'h5555, 46, 0, -1, 6);
    cur_req = "R5 min length";
    send_frame(7, 0, 16'h0800, 8'h45, 8'h11, 8'h4A, 8'h4B, 8'h4C, 16'h4D4E, 47, 0, -1, 6);
    cur_req = "R2";
    send_frame(5, 1, 16'h0800, 8'h45, 8'h11, 8'h33, 8'h33, 8'h33, 16'h3333, 60, 0, -1, 6);
    send_frame(1, 0, 16'h0800, 8'h45, 8'h11, 8'h21, 8'h22, 8'h23, 16'h2425, 60, 0, -1, 6);
    cur_req = "R9";
    repeat (10) drive(8'hFF, 0, 1, s);
    cur_req = "R11";
    send_frame(7, 0, 16'h0800, 8'h45, 8'h11, 8'hA1, 8'hA2, 8'hA3, 16'hA4A5, 60, 0, -1, 0);
    send_frame(7, 0, 16'h0800, 8'h45, 8'h11, 8'hB1, 8'hB2, 8'hB3, 16'hB4B5, 60, 0, -1, 0);
    send_frame(3, 0, 16'h0800, 8'h45, 8'h11, 8'hC1, 8'hC2, 8'hC3, 16'hC4C5, 60, 1, -1, 0);
    send_frame(7, 0, 16'h0800, 8'h45, 8'h11, 8'hD1, 8'hD2, 8'hD3, 16'hD4D5, 60, 0, -1, 8);
    repeat (6) drive(8'h00, 0, 0, s);
    checks++;
    if (exp_cyc_q.size() != 0) begin
      errors++;
      $display("FAIL R5 pending events=%0d expected 0", exp_cyc_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule